// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 level-sensitive interrupt sources behind one memory-mapped register window and drives a single IRQ line towards a processor. Software stores a 32-bit vector word for each source, and it turns sources on or off through separate set and clear command words. When at least one enabled source is active and no interrupt is being serviced, the controller takes the lowest-numbered active source, latches its number and its vector word, and raises IRQ.

The handler reads the vector word. That read is the acknowledge, and it lowers IRQ. The handler can read the latched source number, and that read returns the number and then clears it to zero. Writing the end-of-interrupt command ends service. From then on the next active enabled source can be taken. Source 1 is normally the shared system source, which several peripherals OR together outside the block.

The register port uses single-cycle accesses. Read data comes combinationally from the address. Side effects such as acknowledge, clear-on-read and the commands take place at the clock edge that ends the access.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, IRQ is low, the enable mask reads 0 at offset 0x120, the source-number word at 0x108 reads 0 and every vector word reads 0.
- R2: A write to offset 0x120 sets each enable bit whose data bit is 1 and leaves the other bits unchanged. The mask reads back at 0x120.
- R3: A write to offset 0x124 clears each enable bit whose data bit is 1 and leaves the other bits unchanged.
- R4: The vector word of source i is written and read at byte offset 0x80 + 4*i, with i from 0 to 31.
- R5: An active source whose enable bit is 1 raises IRQ, latches its index at 0x108 and latches its vector word at 0x100. An active source whose enable bit is 0 raises nothing.
- R6: When several enabled sources are active together, the source with the lowest index is taken.
- R7: A read of offset 0x100 returns the latched vector and lowers IRQ after the access.
- R8: A read of offset 0x108 returns the latched source index, and the word reads 0 afterwards.
- R9: A write to offset 0x100 has no effect: IRQ and the latched vector stay as they were.
- R10: After a source is taken, no new IRQ is raised until end-of-interrupt is written at offset 0x130. After that write, a source that is still pending is taken again.
- R11: Offsets that map to no register, including the write-only command words 0x124 and 0x130, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_level | input | N_SRC | Level of each interrupt source, high means active |
| bus_req | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | ADDR_W | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The selection logic is driven with random enable masks and sparse random source patterns, and each outcome is compared with a lowest-set-bit model. Taken together, these runs show whether the enable gating and the lowest-index ordering hold. Directed cases place the active sources at the extreme indices 0 and 31. Directed cases also keep a second source pending during service, which separates a design that waits for end-of-interrupt from one that re-raises IRQ right after the acknowledge. Random vector contents written to all 32 slots expose any aliasing in the address decode. A run of acknowledge reads, junk writes to the vector word and repeated source-number reads tells the side effects of each access apart.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

   localparam int unsigned REG_W   = 32;
   localparam int unsigned OFS_W   = 9;
   localparam int unsigned SLOT_W  = 5;
   localparam int unsigned MAX_SRC = 32;

   // Byte offsets inside the window
   localparam logic [OFS_W-1:0] OFS_TABLE  = 9'h080;
   localparam logic [OFS_W-1:0] OFS_ACKVEC = 9'h100;
   localparam logic [OFS_W-1:0] OFS_SRCNUM = 9'h108;
   localparam logic [OFS_W-1:0] OFS_ENSET  = 9'h120;
   localparam logic [OFS_W-1:0] OFS_ENCLR  = 9'h124;
   localparam logic [OFS_W-1:0] OFS_EOI    = 9'h130;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_TABLE,
      ACC_ACKVEC,
      ACC_SRCNUM,
      ACC_ENSET,
      ACC_ENCLR,
      ACC_EOI
   } acc_kind_e;

   typedef struct packed {
      acc_kind_e          kind;
      logic [SLOT_W-1:0]  slot;
   } acc_dec_t;

endpackage

// File: rtl/irq_vec_decode.sv
module irq_vec_decode
   import irq_vec_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned ADDR_W = 9
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_dec_t          dec
);

   localparam int unsigned HI_W = ADDR_W - OFS_W;

   logic              in_window;
   logic [OFS_W-1:0]  ofs;
   logic              table_hit;

   generate
      if (HI_W > 0) begin : g_hi
         assign in_window = (addr[ADDR_W-1:OFS_W] == '0);
      end else begin : g_nohi
         assign in_window = 1'b1;
      end
   endgenerate

   assign ofs = addr[OFS_W-1:0];

   // Table occupies 0x80..0xFF, word aligned, limited to implemented slots
   assign table_hit = (ofs[8:7] == 2'b01) && (ofs[1:0] == 2'b00)
                    && (32'(ofs[6:2]) < N_SRC);

   always_comb begin
      dec.slot = ofs[6:2];
      dec.kind = ACC_NONE;
      if (in_window) begin
         if (table_hit) begin
            dec.kind = ACC_TABLE;
         end else begin
            unique case (ofs)
               OFS_ACKVEC: dec.kind = ACC_ACKVEC;
               OFS_SRCNUM: dec.kind = ACC_SRCNUM;
               OFS_ENSET:  dec.kind = ACC_ENSET;
               OFS_ENCLR:  dec.kind = ACC_ENCLR;
               OFS_EOI:    dec.kind = ACC_EOI;
               default:    dec.kind = ACC_NONE;
            endcase
         end
      end
   end

endmodule

// File: rtl/irq_vec_enables.sv
module irq_vec_enables #(
   parameter int unsigned N_SRC = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_stb,
   input  logic             clr_stb,
   input  logic [N_SRC-1:0] bits,
   output logic [N_SRC-1:0] mask
);

   logic [N_SRC-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (set_stb) begin
         mask_q <= mask_q | bits;
      end else if (clr_stb) begin
         mask_q <= mask_q & ~bits;
      end
   end

   assign mask = mask_q;

endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table
   import irq_vec_pkg::*;
#(
   parameter int unsigned N_SRC = 32,
   parameter int unsigned VEC_W = 32,
   parameter int unsigned SRC_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [VEC_W-1:0]  wr_val,
   input  logic [SLOT_W-1:0] bus_slot,
   output logic [VEC_W-1:0]  bus_val,
   input  logic [SRC_W-1:0]  pick_slot,
   output logic [VEC_W-1:0]  pick_val
);

   logic [VEC_W-1:0] ent_q [N_SRC];

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ent_q[g] <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
               ent_q[g] <= wr_val;
            end
         end
      end
   endgenerate

   always_comb begin
      bus_val  = '0;
      pick_val = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (bus_slot == SLOT_W'(i))  bus_val  = ent_q[i];
         if (pick_slot == SRC_W'(i))  pick_val = ent_q[i];
      end
   end

endmodule

// File: rtl/irq_vec_pick.sv
module irq_vec_pick #(
   parameter int unsigned N_SRC = 32,
   parameter int unsigned SRC_W = 5
) (
   input  logic [N_SRC-1:0] pend,
   output logic             any,
   output logic [SRC_W-1:0] idx
);

   assign any = |pend;

   generate
      if (N_SRC == 1) begin : g_single
         assign idx = '0;
      end else begin : g_scan
         always_comb begin
            idx = '0;
            // scan downwards so the lowest active index is written last
            for (int i = N_SRC - 1; i >= 0; i--) begin
               if (pend[i]) idx = SRC_W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vec_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned VEC_W  = 32,
   parameter int unsigned ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_level,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);

   localparam int unsigned SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   generate
      if (N_SRC < 1 || N_SRC > MAX_SRC) begin : g_bad_n
         $error("N_SRC must lie in 1..32");
      end
      if (VEC_W < 1 || VEC_W > REG_W) begin : g_bad_w
         $error("VEC_W must lie in 1..32");
      end
      if (ADDR_W < OFS_W) begin : g_bad_a
         $error("ADDR_W must be at least 9");
      end
   endgenerate

   acc_dec_t          dec;
   logic              rd_stb, wr_stb;
   logic [N_SRC-1:0]  en_mask;
   logic [N_SRC-1:0]  pend;
   logic              pend_any;
   logic [SRC_W-1:0]  pend_idx;
   logic [VEC_W-1:0]  table_bus;
   logic [VEC_W-1:0]  table_pick;
   logic              take;

   logic              irq_q;
   logic              in_svc_q;
   logic [SRC_W-1:0]  cur_src_q;
   logic [VEC_W-1:0]  cur_vec_q;

   assign rd_stb = bus_req && !bus_we;
   assign wr_stb = bus_req && bus_we;

   irq_vec_decode #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .dec  (dec)
   );

   irq_vec_enables #(.N_SRC(N_SRC)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (wr_stb && dec.kind == ACC_ENSET),
      .clr_stb (wr_stb && dec.kind == ACC_ENCLR),
      .bits    (bus_wdata[N_SRC-1:0]),
      .mask    (en_mask)
   );

   irq_vec_table #(.N_SRC(N_SRC), .VEC_W(VEC_W), .SRC_W(SRC_W)) u_tab (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_stb && dec.kind == ACC_TABLE),
      .wr_slot   (dec.slot),
      .wr_val    (bus_wdata[VEC_W-1:0]),
      .bus_slot  (dec.slot),
      .bus_val   (table_bus),
      .pick_slot (pend_idx),
      .pick_val  (table_pick)
   );

   assign pend = src_level & en_mask;

   irq_vec_pick #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_pick (
      .pend (pend),
      .any  (pend_any),
      .idx  (pend_idx)
   );

   assign take = pend_any && !in_svc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q     <= 1'b0;
         in_svc_q  <= 1'b0;
         cur_src_q <= '0;
         cur_vec_q <= '0;
      end else if (take) begin
         irq_q     <= 1'b1;
         in_svc_q  <= 1'b1;
         cur_src_q <= pend_idx;
         cur_vec_q <= table_pick;
      end else begin
         if (rd_stb && dec.kind == ACC_ACKVEC) irq_q     <= 1'b0;
         if (rd_stb && dec.kind == ACC_SRCNUM) cur_src_q <= '0;
         if (wr_stb && dec.kind == ACC_EOI)    in_svc_q  <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (dec.kind)
         ACC_TABLE:  bus_rdata = 32'(table_bus);
         ACC_ACKVEC: bus_rdata = 32'(cur_vec_q);
         ACC_SRCNUM: bus_rdata = 32'(cur_src_q);
         ACC_ENSET:  bus_rdata = 32'(en_mask);
         default:    bus_rdata = '0;
      endcase
   end

   assign irq = irq_q;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
   import irq_vec_pkg::*;
#(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned SRC_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              irq,
   input logic [N_SRC-1:0]  en_mask,
   input logic              in_svc,
   input logic [SRC_W-1:0]  cur_src
);

   logic hit_set, hit_clr, hit_ack, hit_num;
   assign hit_set = bus_req && bus_we  && bus_addr == ADDR_W'(OFS_ENSET);
   assign hit_clr = bus_req && bus_we  && bus_addr == ADDR_W'(OFS_ENCLR);
   assign hit_ack = bus_req && (bus_addr == ADDR_W'(OFS_ACKVEC));
   assign hit_num = bus_req && !bus_we && bus_addr == ADDR_W'(OFS_SRCNUM);

   // R2
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_set |=> ((en_mask & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

   // R3
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_clr |=> ((en_mask & $past(bus_wdata[N_SRC-1:0])) == '0));

   // R7
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ack && !bus_we && irq) |=> !irq);

   // R9
   ack_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ack && bus_we && irq) |=> irq);

   // R8
   num_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_num && in_svc) |=> (cur_src == '0));

   // R10
   hold_in_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_svc |=> !$rose(irq));

   // R5
   rise_marks_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> in_svc);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
   .N_SRC  (N_SRC),
   .ADDR_W (ADDR_W),
   .SRC_W  (SRC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .en_mask   (en_mask),
   .in_svc    (in_svc_q),
   .cur_src   (cur_src_q)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;

   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] src_level = '0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] vec_m [N];

   always #5 clk = ~clk;

   irq_vector_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_level(src_level),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic int lowest(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return -1;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_req = 1'b0;
      #1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #1000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] d, a, b, c;
      void'($urandom(32'h1BADC0DE));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      check("R1 irq", {31'b0, irq}, 32'h0);
      rd(9'h120, d); check("R1 mask", d, 0);
      rd(9'h108, d); check("R1 srcnum", d, 0);
      rd(9'h0FC, d); check("R1 vector", d, 0);

      // R4 vector table
      for (int i = 0; i < N; i++) begin
         vec_m[i] = $urandom;
         wr(9'(9'h080 + 4*i), vec_m[i]);
      end
      for (int i = N - 1; i >= 0; i--) begin
         rd(9'(9'h080 + 4*i), d); check("R4 table", d, vec_m[i]);
      end

      // R11 unmapped and write-only words
      rd(9'h004, d); check("R11 0x004", d, 0);
      rd(9'h104, d); check("R11 0x104", d, 0);
      rd(9'h124, d); check("R11 0x124", d, 0);
      rd(9'h130, d); check("R11 0x130", d, 0);
      rd(9'h1FC, d); check("R11 0x1FC", d, 0);

      // R2 / R3 enable set and clear
      a = $urandom; b = $urandom; c = $urandom;
      wr(9'h120, a); wr(9'h120, b);
      rd(9'h120, d); check("R2 set", d, a | b);
      wr(9'h124, c);
      rd(9'h120, d); check("R3 clear", d, (a | b) & ~c);

      // R5 disabled source raises nothing
      wr(9'h124, 32'hFFFF_FFFF);
      src_level = 32'h10;
      idle(4);
      check("R5 masked", {31'b0, irq}, 0);
      wr(9'h120, 32'h10);
      idle(3);
      check("R5 irq", {31'b0, irq}, 1);
      // R9 write to vector word ignored
      wr(9'h100, ~vec_m[4]);
      check("R9 irq kept", {31'b0, irq}, 1);
      rd(9'h100, d); check("R9 R5 vector", d, vec_m[4]);
      check("R7 irq dropped", {31'b0, irq}, 0);
      rd(9'h108, d); check("R8 srcnum", d, 4);
      rd(9'h108, d); check("R8 cleared", d, 0);
      src_level = '0;
      wr(9'h130, 0);
      idle(3);

      // R10 second source waits for end-of-interrupt
      wr(9'h120, 32'h28);
      src_level = 32'h28;
      idle(3);
      rd(9'h100, d); check("R6 R10 first vector", d, vec_m[3]);
      idle(5);
      check("R10 held", {31'b0, irq}, 0);
      src_level = 32'h20;
      idle(3);
      check("R10 still held", {31'b0, irq}, 0);
      wr(9'h130, 0);
      idle(3);
      check("R10 retaken irq", {31'b0, irq}, 1);
      rd(9'h108, d); check("R10 retaken src", d, 5);
      rd(9'h100, d);
      src_level = '0;
      wr(9'h130, 0);
      idle(3);

      // R6 extreme indices
      wr(9'h120, 32'hFFFF_FFFF);
      src_level = 32'h8000_0001;
      idle(3);
      rd(9'h108, d); check("R6 index0", d, 0);
      rd(9'h100, d); check("R6 vector0", d, vec_m[0]);
      src_level = '0;
      wr(9'h130, 0);
      src_level = 32'h8000_0000;
      idle(3);
      rd(9'h108, d); check("R6 index31", d, 31);
      rd(9'h100, d); check("R6 vector31", d, vec_m[31]);
      src_level = '0;
      wr(9'h130, 0);
      idle(2);

      // R5 R6 random patterns
      for (int k = 0; k < 60; k++) begin
         logic [31:0] m, l;
         int e;
         m = $urandom;
         l = $urandom & $urandom & $urandom;
         e = lowest(l & m);
         wr(9'h124, 32'hFFFF_FFFF);
         wr(9'h120, m);
         src_level = l;
         idle(3);
         check("R5 random irq", {31'b0, irq}, (e >= 0) ? 1 : 0);
         if (e >= 0) begin
            rd(9'h108, d); check("R6 random index", d, e);
            rd(9'h100, d); check("R6 random vector", d, vec_m[e]);
            check("R7 random drop", {31'b0, irq}, 0);
         end
         src_level = '0;
         wr(9'h130, 0);
         idle(2);
      end

      finish_run();
   end

endmodule